// File: doc/BRIEF.md
# Microsecond Free-Running Timer with Periodic Ticks

This block is an up-counter that never stops on its own. A prescaler divides the system clock by a fixed ratio (six by default, so a 6 MHz clock gives a 1 µs count step). Each step advances an 8-bit count, and software reads that count as a read-only value. The count has no reload, no compare register and no write path. It wraps from its top value to zero and keeps counting.

The block derives two periodic interrupt request pulses from the count. The fast tick fires each time count bit 6 falls, which is every 128 steps (128 µs). A small extension counter counts wraps of the 8-bit count, and the slow tick fires on every fourth wrap, which is every 1024 steps (1.024 ms). The interrupt controller that consumes the ticks is outside the block. While the device is suspended, a suspend input freezes the whole timer, including the prescaler phase.

Top module: `usec_tick_timer`

## Requirements
- R1: A synchronous reset sets the count to 0, sets the prescaler phase and the wrap counter to 0, and holds both tick outputs low.
- R2: While suspend is low, the count rises by exactly one every 6 clock edges. The first increment after reset is on the 6th active edge, so after k active edges the count reads floor(k/6) mod 256.
- R3: The count is free-running. After 255 the next step gives 0, and it continues from there without any reload.
- R4: The fast tick is high for exactly one cycle: the cycle in which the count first shows a value whose bit 6 is 0 after a value whose bit 6 was 1 (the count shows 0x80 or 0x00). This happens every 768 active clocks.
- R5: The slow tick is high for exactly one cycle, on every fourth wrap of the count (the count shows 0x00). This happens every 6144 active clocks.
- R6: While suspend is high, the count, the prescaler phase and the wrap counter all hold, and both ticks stay low. When suspend returns low, counting resumes from the held phase, so suspended clocks simply do not count.
- R7: On a slow tick, the fast tick is high in the same cycle.
- R8: Reset takes priority over suspend. A reset while suspend is high still clears all state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock (resonator rate) |
| rst_i | input | 1 | Synchronous reset, active high |
| suspend_i | input | 1 | Freezes all timer state while high |
| count_o | output | 8 | Current timer value, read-only |
| tick_fast_o | output | 1 | One-cycle pulse every 128 count steps |
| tick_slow_o | output | 1 | One-cycle pulse every 1024 count steps |

## Verification
The two ticks meet whenever the count wraps to zero on a fourth wrap, because bit 6 also falls on that step. The bench runs the timer to the active clock just before the 6144th. It checks that the count reads 255 there, then advances one edge and requires both pulses high together with a zero count. On the next edge it requires both pulses low. A second run freezes the timer one clock short of a fast tick, to show that the pending pulse is held back rather than lost or doubled.

// File: rtl/utmr_pkg.sv
package utmr_pkg;
   // Width of a counter that must hold values 0 .. n-1 (at least one bit).
   function automatic int unsigned span_width(input int unsigned n);
      int unsigned w;
      w = 1;
      while ((1 << w) < n) w++;
      return w;
   endfunction
endpackage

// File: rtl/utmr_prescale.sv
module utmr_prescale #(
   parameter int unsigned DIV = 6
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic hold_i,
   output logic step_o
);
   import utmr_pkg::*;
   localparam int unsigned PH_W = span_width(DIV);

   if (DIV < 1) begin : g_bad_div
      $error("utmr_prescale: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_bypass
      assign step_o = !hold_i;
   end else begin : g_divide
      logic [PH_W-1:0] phase_q;
      logic            last_ph;

      assign last_ph = (phase_q == PH_W'(DIV - 1));
      assign step_o  = !hold_i && last_ph;

      always_ff @(posedge clk_i) begin
         if (rst_i)
            phase_q <= '0;
         else if (!hold_i)
            phase_q <= last_ph ? '0 : phase_q + 1'b1;
      end

      AST_PHASE_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
         phase_q <= PH_W'(DIV - 1)); // R2
      AST_PHASE_FROZEN: assert property (@(posedge clk_i) disable iff (rst_i)
         hold_i |=> $stable(phase_q)); // R6
   end
endmodule

// File: rtl/utmr_core.sv
module utmr_core #(
   parameter int unsigned CNT_W    = 8,
   parameter int unsigned FAST_BIT = 6
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             step_i,
   output logic [CNT_W-1:0] count_o,
   output logic             wrap_o,
   output logic             tick_fast_o
);
   if (FAST_BIT >= CNT_W) begin : g_bad_bit
      $error("utmr_core: FAST_BIT must lie inside the count");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             fast_q;
   logic             fall_evt;

   // Bit FAST_BIT falls on the step where all bits up to it are ones.
   assign fall_evt = step_i && (&cnt_q[FAST_BIT:0]);
   assign wrap_o   = step_i && (&cnt_q);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cnt_q  <= '0;
         fast_q <= 1'b0;
      end else begin
         fast_q <= fall_evt;
         if (step_i) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign count_o     = cnt_q;
   assign tick_fast_o = fast_q;

   AST_CNT_ADVANCE: assert property (@(posedge clk_i) disable iff (rst_i)
      step_i |=> cnt_q == $past(cnt_q) + 1'b1); // R2
   AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
      !step_i |=> $stable(cnt_q)); // R6
   AST_FAST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i)
      fast_q |=> !fast_q); // R4
   AST_FAST_ALIGNED: assert property (@(posedge clk_i) disable iff (rst_i)
      fast_q |-> cnt_q[FAST_BIT:0] == '0); // R4
endmodule

// File: rtl/utmr_wrap_ext.sv
module utmr_wrap_ext #(
   parameter int unsigned EXT_W = 3,
   parameter int unsigned WRAPS = 4
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic wrap_i,
   output logic tick_slow_o
);
   if (WRAPS < 1 || WRAPS > (1 << EXT_W)) begin : g_bad_wraps
      $error("utmr_wrap_ext: WRAPS must fit the extension counter");
   end

   logic [EXT_W-1:0] ext_q;
   logic             slow_q;
   logic             last_wrap;

   assign last_wrap = (ext_q == EXT_W'(WRAPS - 1));

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         ext_q  <= '0;
         slow_q <= 1'b0;
      end else begin
         slow_q <= wrap_i && last_wrap;
         if (wrap_i) ext_q <= last_wrap ? '0 : ext_q + 1'b1;
      end
   end

   assign tick_slow_o = slow_q;

   AST_EXT_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
      ext_q <= EXT_W'(WRAPS - 1)); // R5
   AST_EXT_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
      !wrap_i |=> $stable(ext_q)); // R6
   AST_SLOW_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i)
      slow_q |=> !slow_q); // R5
endmodule

// File: rtl/usec_tick_timer.sv
module usec_tick_timer #(
   parameter int unsigned PRESCALE_DIV = 6,
   parameter int unsigned CNT_W        = 8,
   parameter int unsigned FAST_BIT     = 6,
   parameter int unsigned EXT_W        = 3,
   parameter int unsigned SLOW_WRAPS   = 4
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             suspend_i,
   output logic [CNT_W-1:0] count_o,
   output logic             tick_fast_o,
   output logic             tick_slow_o
);
   logic step;
   logic wrap;

   utmr_prescale #(.DIV(PRESCALE_DIV)) u_pre (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .hold_i (suspend_i),
      .step_o (step)
   );

   utmr_core #(.CNT_W(CNT_W), .FAST_BIT(FAST_BIT)) u_core (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .step_i      (step),
      .count_o     (count_o),
      .wrap_o      (wrap),
      .tick_fast_o (tick_fast_o)
   );

   utmr_wrap_ext #(.EXT_W(EXT_W), .WRAPS(SLOW_WRAPS)) u_ext (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .wrap_i      (wrap),
      .tick_slow_o (tick_slow_o)
   );

   AST_SUSPEND_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
      suspend_i |=> !tick_fast_o && !tick_slow_o); // R6
   AST_SLOW_WITH_FAST: assert property (@(posedge clk_i) disable iff (rst_i)
      tick_slow_o |-> tick_fast_o); // R7
   AST_SLOW_AT_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
      tick_slow_o |-> count_o == '0); // R5
   AST_RESET_CLEARS: assert property (@(posedge clk_i)
      rst_i |=> count_o == '0 && !tick_fast_o && !tick_slow_o); // R1 R8
endmodule

// File: tb/usec_tick_timer_tb.sv
`timescale 1ns/1ps
module usec_tick_timer_tb;
   localparam int DIV       = 6;
   localparam int FAST_PER  = 128 * DIV;
   localparam int SLOW_PER  = 1024 * DIV;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       suspend = 1'b0;
   logic [7:0] count;
   logic       tick_fast;
   logic       tick_slow;

   int vectors = 0;
   int misses  = 0;
   int act     = 0;   // active (non-suspended) edges since reset release
   bit done    = 1'b0;

   always #2 clk = ~clk;

   usec_tick_timer u_dut (
      .clk_i       (clk),
      .rst_i       (rst),
      .suspend_i   (suspend),
      .count_o     (count),
      .tick_fast_o (tick_fast),
      .tick_slow_o (tick_slow)
   );

   task automatic check(input bit ok, input string req, input int actual, input int expected);
      vectors++;
      if (!ok) begin
         misses++;
         $display("FAIL %s: actual %0d expected %0d (active edge %0d)", req, actual, expected, act);
      end
   endtask

   // Advance n edges with the given suspend level, checking outputs after each edge.
   task automatic adv(input int n, input bit susp);
      for (int i = 0; i < n; i++) begin
         suspend = susp;
         @(posedge clk);
         if (!susp) act++;
         @(negedge clk);
         check(count == 8'((act / DIV) % 256), susp ? "R6" : "R2", count, (act / DIV) % 256);
         check(tick_fast == (!susp && act % FAST_PER == 0), "R4", tick_fast,
               int'(!susp && act % FAST_PER == 0));
         check(tick_slow == (!susp && act % SLOW_PER == 0), "R5", tick_slow,
               int'(!susp && act % SLOW_PER == 0));
      end
   endtask

   task automatic run_to(input int target);
      while (act < target) adv(1, 1'b0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      rst = 1'b1; suspend = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check(count == 8'd0, "R1", count, 0);
      check(!tick_fast && !tick_slow, "R1", {tick_fast, tick_slow}, 0);
      rst = 1'b0;
      act = 0;
   endtask

   task automatic t_rate();
      adv(5, 1'b0);
      check(count == 8'd0, "R2", count, 0);
      adv(1, 1'b0);
      check(count == 8'd1, "R2", count, 1);
      adv(794, 1'b0);
      check(count == 8'd133, "R2", count, 133);
   endtask

   task automatic t_suspend_hold();
      logic [7:0] held;
      adv(3, 1'b0);
      held = count;
      adv(40, 1'b1);
      check(count == held, "R6", count, held);
      adv(10, 1'b0);
   endtask

   task automatic t_suspend_before_fast();
      run_to(2 * FAST_PER - 1);
      adv(9, 1'b1);
      check(!tick_fast, "R6", tick_fast, 0);
      adv(1, 1'b0);
      check(tick_fast && count == 8'd0, "R4", {tick_fast, count}, 256);
      adv(1, 1'b0);
      check(!tick_fast, "R4", tick_fast, 0);
   endtask

   task automatic t_wrap_and_coincide();
      run_to(SLOW_PER - 1);
      check(count == 8'd255, "R3", count, 255);
      adv(1, 1'b0);
      check(count == 8'd0, "R3", count, 0);
      check(tick_slow && tick_fast, "R7", {tick_slow, tick_fast}, 3);
      adv(1, 1'b0);
      check(!tick_slow && !tick_fast, "R5", {tick_slow, tick_fast}, 0);
   endtask

   task automatic t_reset_in_suspend();
      adv(20, 1'b0);
      @(negedge clk);
      suspend = 1'b1; rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check(count == 8'd0 && !tick_fast && !tick_slow, "R8", count, 0);
      rst = 1'b0;
      act = 0;
      adv(12, 1'b0);
      check(count == 8'd2, "R8", count, 2);
   endtask

   initial begin
      t_reset();
      t_rate();
      t_suspend_hold();
      t_suspend_before_fast();
      t_wrap_and_coincide();
      t_reset_in_suspend();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         vectors++;
         misses++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end
endmodule